// File: doc/BRIEF.md
# RTC Periodic Interrupt Divider

This block is the prescaler and periodic-rate section of a real-time clock. A 32.768 kHz oscillator arrives as a one-cycle enable on the system clock. That enable advances a 15-stage binary divider. A 4-bit rate code picks one divider tap. Each time the selected tap completes a period, a sticky periodic flag is set. The flag can drive an interrupt line, and the top of the divider produces a one-second carry pulse.

Software controls the block through one 8-bit configuration write. The upper field decides whether the divider counts or is held in reset. The lower field is the rate code. The flag is cleared by a status-read strobe. A small two-state machine governs the divider. In `ST_HOLD` the chain is parked at its midpoint. In `ST_RUN` it counts oscillator ticks. There are two transitions. The release, from `ST_HOLD` to `ST_RUN`, happens when the control field equals 010. The park, from `ST_RUN` to `ST_HOLD`, happens when the control field takes any other value. Parking at the midpoint puts the first one-second carry half a second after release, while every tap below the top stage starts from zero.

Top module: `rtc_periodic_div`

## Requirements
- R1: A write with `cfg_we` high loads bits 6:4 of `cfg_wdata` as the divider-control field and bits 3:0 as the rate code. Bit 7 is ignored.
- R2: The divider counts only while the divider-control field is 010. Any other value, including 000, 001, 110 and 111, holds the chain, so no flag and no carry occur.
- R3: `rst_n` low clears the flag and the carry and parks the chain. The configuration fields keep their values through it, so a chain configured to run restarts by itself after reset.
- R4: After the chain starts counting, the first flag comes exactly one tap period later. The flag is visible one clock after the oscillator tick that completes the period. The first `sec_carry` comes 16384 ticks after the chain starts.
- R5: For rate codes 3 to 15, the tap period is 2^(code-1) ticks. Code 1 gives 128 ticks, the same as code 8. Code 2 gives 256 ticks, the same as code 9.
- R6: Rate code 0 never sets the flag.
- R7: A `flag_rd` pulse clears the flag. `irq` equals the flag ANDed with `pie`.
- R8: When a `flag_rd` pulse and a completed tap period fall in the same cycle, the flag stays set.
- R9: A new rate code written while running takes effect only at the next tap edge of the old rate. The old edge still sets the flag once, and later flags follow the new rate.
- R10: `sec_carry` is a one-cycle pulse. It occurs once for every 32768 counted ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; leaves the configuration untouched |
| osc_en | input | 1 | One-cycle pulse per 32.768 kHz oscillator tick |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| flag_rd | input | 1 | Status-read strobe; clears the periodic flag |
| pie | input | 1 | Periodic interrupt enable |
| pflag | output | 1 | Sticky periodic flag |
| irq | output | 1 | Periodic interrupt request |
| sec_carry | output | 1 | One-cycle pulse at each one-second rollover |

## Verification
The flag's set path and its read-clear path can act in the same clock cycle. In that case the set path must take priority. The bench provokes the collision by running rate code 3 from release, giving three ticks, and then driving `flag_rd` high in the very cycle that carries the fourth tick. The collision is judged correct when the flag still reads 1 afterwards and a following lone read clears it.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

    localparam int DV_W   = 3;
    localparam int RATE_W = 4;

    localparam logic [DV_W-1:0] DV_RUN = 3'b010;

    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

    // Codes 1 and 2 reuse the taps of codes 8 and 9; others use code-1.
    function automatic logic [RATE_W-1:0] tap_shift(input logic [RATE_W-1:0] code);
        if (code < 4'd3)
            return code + 4'd6;
        else
            return code - 4'd1;
    endfunction

endpackage

// File: rtl/rtc_cfg_reg.sv
module rtc_cfg_reg
    import rtc_div_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic              clk,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              upd_ok,
    output logic [DV_W-1:0]   dv,
    output logic [RATE_W-1:0] rate_act
);

    localparam int FIELD_W = DV_W + RATE_W;

    logic [DV_W-1:0]   dv_q;
    logic [RATE_W-1:0] rate_pend_q;
    logic [RATE_W-1:0] rate_act_q;

    generate
        if (CFG_W > FIELD_W) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^cfg_wdata[CFG_W-1:FIELD_W];
        end
    endgenerate

    // No reset on purpose: the fields survive every system reset.
    always_ff @(posedge clk) begin
        if (cfg_we) begin
            dv_q        <= cfg_wdata[FIELD_W-1:RATE_W];
            rate_pend_q <= cfg_wdata[RATE_W-1:0];
        end
        if (upd_ok)
            rate_act_q <= cfg_we ? cfg_wdata[RATE_W-1:0] : rate_pend_q;
    end

    assign dv       = dv_q;
    assign rate_act = rate_act_q;

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
    import rtc_div_pkg::*;
#(
    parameter int STAGES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic [DV_W-1:0]   dv,
    input  logic [RATE_W-1:0] rate,
    output logic              running,
    output logic              tap_evt,
    output logic              upd_ok,
    output logic              sec_carry
);

    localparam logic [STAGES-1:0] HALF = {1'b1, {(STAGES-1){1'b0}}};
    localparam logic [STAGES-1:0] ONE  = {{(STAGES-1){1'b0}}, 1'b1};

    div_state_e        state_q, state_d;
    logic [STAGES-1:0] cnt_q;
    logic [STAGES-1:0] mask;
    logic              wrap;
    logic              carry_q;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (dv == DV_RUN) state_d = ST_RUN;
            ST_RUN:  if (dv != DV_RUN) state_d = ST_HOLD;
        endcase
    end

    // State register, divider and carry register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= HALF;
            carry_q <= 1'b0;
        end else begin
            state_q <= state_d;
            carry_q <= wrap;
            if (state_q != ST_RUN)
                cnt_q <= HALF;
            else if (osc_en)
                cnt_q <= cnt_q + ONE;
        end
    end

    // Outputs decoded from state and divider.
    always_comb begin
        running = (state_q == ST_RUN);
        mask    = (ONE << tap_shift(rate)) - ONE;
        tap_evt = osc_en && running && (rate != '0) && ((cnt_q & mask) == mask);
        wrap    = osc_en && running && (&cnt_q);
        upd_ok  = !running || (rate == '0) || tap_evt;
    end

    assign sec_carry = carry_q;

    AST_CARRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_carry |=> !sec_carry); // R10

endmodule

// File: rtl/rtc_pflag.sv
module rtc_pflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_clr,
    input  logic pie,
    output logic flag,
    output logic irq
);

    logic flag_q;

    // A set in the same cycle as a read wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_evt)
            flag_q <= 1'b1;
        else if (rd_clr)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign irq  = flag_q & pie;

endmodule

// File: rtl/rtc_periodic_div.sv
module rtc_periodic_div
    import rtc_div_pkg::*;
#(
    parameter int STAGES = 15,
    parameter int CFG_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             flag_rd,
    input  logic             pie,
    output logic             pflag,
    output logic             irq,
    output logic             sec_carry
);

    logic [DV_W-1:0]   dv;
    logic [RATE_W-1:0] rate_act;
    logic              running;
    logic              tap_evt;
    logic              upd_ok;

    rtc_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk      (clk),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .upd_ok   (upd_ok),
        .dv       (dv),
        .rate_act (rate_act)
    );

    rtc_div_chain #(.STAGES(STAGES)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .dv       (dv),
        .rate     (rate_act),
        .running  (running),
        .tap_evt  (tap_evt),
        .upd_ok   (upd_ok),
        .sec_carry(sec_carry)
    );

    rtc_pflag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(tap_evt),
        .rd_clr (flag_rd),
        .pie    (pie),
        .flag   (pflag),
        .irq    (irq)
    );

    AST_NO_FLAG_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !pflag) |=> !pflag); // R2
    AST_RATE0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_act == '0 && !pflag) |=> !pflag); // R6
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !tap_evt) |=> !pflag); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        tap_evt |=> pflag); // R8

endmodule

// File: tb/rtc_periodic_div_tb.sv
module rtc_periodic_div_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       flag_rd = 1'b0;
    logic       pie = 1'b0;
    logic       pflag, irq, sec_carry;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_periodic_div u_dut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .flag_rd(flag_rd), .pie(pie),
        .pflag(pflag), .irq(irq), .sec_carry(sec_carry)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) osc_en = 1'b1;
        @(negedge clk) osc_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk) begin cfg_we = 1'b1; cfg_wdata = v; end
        @(negedge clk) cfg_we = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk) flag_rd = 1'b1;
        @(negedge clk) flag_rd = 1'b0;
    endtask

    function automatic int period_of(input int code);
        if (code == 1 || code == 2) return 1 << (code + 6);
        return 1 << (code - 1);
    endfunction

    // Park, clear, release with the given code, count ticks to first flag.
    task automatic measure(input int code, output int n_flag, output int n_carry, output int carries);
        wr(8'h60 | 8'(code));
        rd();
        wr(8'h20 | 8'(code));
        n_flag = 0; n_carry = 0; carries = 0;
        for (int i = 1; i <= 20000; i++) begin
            tick();
            if (sec_carry) begin
                carries++;
                if (n_carry == 0) n_carry = i;
            end
            if (pflag) begin
                n_flag = i;
                break;
            end
        end
    endtask

    task automatic t_reset();
        chk("R3 reset flag", int'(pflag), 0);
        chk("R3 reset irq", int'(irq), 0);
        chk("R3 reset carry", int'(sec_carry), 0);
    endtask

    task automatic t_hold();
        wr(8'h63); rd(); ticks(40);
        chk("R2 hold 110", int'(pflag), 0);
        wr(8'h73); ticks(40);
        chk("R2 hold 111", int'(pflag), 0);
        wr(8'h03); ticks(40);
        chk("R2 hold 000", int'(pflag), 0);
        wr(8'h13); ticks(40);
        chk("R2 hold 001", int'(pflag), 0);
        // Bit 7 set alongside run code: still runs at code 3
        wr(8'hE3); rd(); wr(8'hA3); ticks(4);
        chk("R1 bit7 ignored, run", int'(pflag), 1);
    endtask

    task automatic t_rates();
        int codes [7] = '{3, 7, 10, 1, 8, 2, 9};
        int nf, nc, cc;
        foreach (codes[k]) begin
            measure(codes[k], nf, nc, cc);
            chk($sformatf("R5 code %0d period", codes[k]), nf, period_of(codes[k]));
        end
    endtask

    task automatic t_carry();
        int nf, nc, cc;
        measure(15, nf, nc, cc);
        chk("R4 first flag code 15", nf, 16384);
        chk("R4 first carry tick", nc, 16384);
        chk("R10 carry count", cc, 1);
        @(negedge clk);
        chk("R10 carry one cycle", int'(sec_carry), 0);
    endtask

    task automatic t_code0();
        wr(8'h60); rd(); wr(8'h20); ticks(300);
        chk("R6 code 0 silent", int'(pflag), 0);
    endtask

    task automatic t_irq();
        int nf, nc, cc;
        measure(3, nf, nc, cc);
        chk("R4 first flag code 3", nf, 4);
        pie = 1'b0; @(negedge clk);
        chk("R7 irq masked", int'(irq), 0);
        pie = 1'b1; @(negedge clk);
        chk("R7 irq enabled", int'(irq), 1);
        rd();
        chk("R7 read clears flag", int'(pflag), 0);
        chk("R7 irq follows flag", int'(irq), 0);
        pie = 1'b0;
    endtask

    task automatic t_collide();
        wr(8'h63); rd(); wr(8'h23); ticks(3);
        chk("R8 before edge", int'(pflag), 0);
        @(negedge clk) begin osc_en = 1'b1; flag_rd = 1'b1; end
        @(negedge clk) begin osc_en = 1'b0; flag_rd = 1'b0; end
        chk("R8 set wins over read", int'(pflag), 1);
        rd();
        chk("R7 lone read clears", int'(pflag), 0);
    endtask

    task automatic t_ratechg();
        wr(8'h63); rd(); wr(8'h23); ticks(4);
        chk("R9 initial edge", int'(pflag), 1);
        rd(); tick();
        wr(8'h24); ticks(2);
        chk("R9 no early flag", int'(pflag), 0);
        tick();
        chk("R9 old-rate edge", int'(pflag), 1);
        rd(); ticks(7);
        chk("R9 new rate not yet", int'(pflag), 0);
        tick();
        chk("R9 new rate edge", int'(pflag), 1);
    endtask

    task automatic t_persist();
        wr(8'h63); rd(); wr(8'h23); tick();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R3 reset clears flag", int'(pflag), 0);
        ticks(3);
        chk("R3 restart phase", int'(pflag), 0);
        tick();
        chk("R3 config kept", int'(pflag), 1);
        rd();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold();
        t_rates();
        t_code0();
        t_irq();
        t_collide();
        t_ratechg();
        t_persist();
        t_carry();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule